// File: doc/BRIEF.md
# Coalescing Write Stream

This block sits between one output of a loop accelerator and a shared memory port. Every word the circuit produces arrives as a word address plus data. It is first queued in a word FIFO, then folded into a one-block staging latch. The latch keeps one valid bit per word slot. Several words that land in the same block therefore leave as one block write, with a per-word enable vector. Sending the block is deliberately held back until the FIFO is at least half full. This gives later words time to coalesce. The block also publishes an urgency value that a shared arbiter can compare against other streams.

The controller is a three-state machine:
- `ST_MERGE`: the FIFO head is moved into the latch, one word per cycle.
- `ST_HOLD`: the latch must be sent, but the FIFO is below the half-full mark and no end-of-stream word is queued.
- `ST_SEND`: `mem_req` is raised with the latch contents until `mem_ack` arrives.

The transitions are:
- MERGE→SEND: an end-of-stream word merged, or a flush is needed and allowed.
- MERGE→HOLD: a flush is needed but not yet allowed.
- HOLD→SEND: the flush became allowed.
- SEND→MERGE: on acknowledge.

Top module: `coalescing_write_stream`

## Requirements
- R1: After reset, `in_ready` is 1, `mem_req` is 0 and `prio` equals WORDS (8).
- R2: `prio` equals WORDS minus the number of words held in the FIFO. It is updated on the clock edge that accepts or removes a word, so a word accepted into an empty FIFO lowers `prio` to 7, and `prio` returns to 8 one edge later when the word moves into the latch.
- R3: `in_ready` is 0 exactly while the FIFO holds WORDS words, and `prio` is then 0. A write presented while `in_ready` is 0 is dropped and never reaches memory.
- R4: Words of one block at distinct offsets merge into a single request in any arrival order. Word address bits [2:0] are the offset and the remaining bits are `mem_blk`. `mem_wen` bit i is set for each offset i written, and the data of offset i sits in `mem_data[32*i+31:32*i]`.
- R5: A word whose offset is already filled in the latch forces the latch out first. The new value then travels in a later request, so memory ends with the newest value.
- R6: A word whose block differs from the block in the latch forces the latch out before that word merges.
- R7: When a flush is needed and no end-of-stream word is queued, `mem_req` stays 0 while the FIFO holds fewer than WORDS/2 words. After the edge that brings the count to WORDS/2, `mem_req` rises on the following edge.
- R8: A word tagged with `in_last` causes the latch to be sent once that word has merged, whatever the FIFO level.
- R9: Once raised, `mem_req` stays 1 with a stable `mem_blk`, `mem_wen` and `mem_data` until `mem_ack` is seen, and drops on the next edge. The latch is emptied only by that acknowledge.
- R10: After a stream has fully drained, memory holds exactly the result of applying all accepted writes in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Circuit offers a write |
| in_ready | output | 1 | FIFO can accept a write this cycle |
| in_addr | input | ADDR_W | Word address of the write |
| in_data | input | DATA_W | Write data |
| in_last | input | 1 | This write ends the stream |
| mem_req | output | 1 | Block write request to memory |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_blk | output | ADDR_W-3 | Block address of the request |
| mem_wen | output | WORDS | Per-word write enables |
| mem_data | output | WORDS*DATA_W | Block data, word i in slice i |
| prio | output | 4 | Arbitration urgency: free FIFO slots |

## Verification
Each result has a fixed cycle offset from its stimulus:
- `prio` moves on the accepting edge itself.
- A queued word reaches the latch one edge after it is accepted.
- `mem_req` rises one edge after the machine decides to send, because it is decoded from the state register.
- `mem_req` drops on the edge after `mem_ack`.

Inputs are driven just after a rising edge, or at a falling edge, and outputs are read at falling edges. The threshold check therefore samples `mem_req` twice after the count reaches four: once low and once high. The memory model acknowledges a fixed number of cycles after the request and logs each request, so request count and payload checks do not depend on event order.

// File: rtl/cws_pkg.sv
package cws_pkg;
    typedef enum logic [1:0] {
        ST_MERGE = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SEND  = 2'd2
    } cws_state_e;
endpackage

// File: rtl/cws_word_fifo.sv
module cws_word_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 49
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/cws_merge_latch.sv
module cws_merge_latch #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [BLK_W-1:0]           load_blk,
    input  logic [$clog2(WORDS)-1:0]   load_off,
    input  logic [DATA_W-1:0]          load_data,
    input  logic                       clear,
    output logic [BLK_W-1:0]           blk,
    output logic [WORDS-1:0]           mask,
    output logic [WORDS*DATA_W-1:0]    data,
    output logic                       is_full,
    output logic                       is_empty
);
    localparam int OFF_W = $clog2(WORDS);

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic              slot_vld;
        logic [DATA_W-1:0] slot_q;
        logic              hit;
        assign hit = load && (load_off == OFF_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_vld <= 1'b0;
                slot_q   <= '0;
            end else if (clear) begin
                slot_vld <= 1'b0;
            end else if (hit) begin
                slot_vld <= 1'b1;
                slot_q   <= load_data;
            end
        end
        assign mask[g] = slot_vld;
        assign data[g*DATA_W +: DATA_W] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blk <= '0;
        else if (load) blk <= load_blk;
    end

    assign is_full  = &mask;
    assign is_empty = ~|mask;
endmodule

// File: rtl/coalescing_write_stream.sv
module coalescing_write_stream
    import cws_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [ADDR_W-1:0]                    in_addr,
    input  logic [DATA_W-1:0]                    in_data,
    input  logic                                 in_last,
    output logic                                 mem_req,
    input  logic                                 mem_ack,
    output logic [ADDR_W-$clog2(WORDS)-1:0]      mem_blk,
    output logic [WORDS-1:0]                     mem_wen,
    output logic [WORDS*DATA_W-1:0]              mem_data,
    output logic [$clog2(WORDS+1)-1:0]           prio
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int CNT_W = $clog2(WORDS+1);
    localparam int HALF  = WORDS / 2;
    localparam int ENT_W = 1 + ADDR_W + DATA_W;

    cws_state_e state, nxt;

    logic             push, pop, lat_clear;
    logic [ENT_W-1:0] head;
    logic [CNT_W-1:0] fifo_count, eos_cnt;
    logic             fifo_full, fifo_empty;
    logic             head_last;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [OFF_W-1:0] head_off;
    logic [BLK_W-1:0] head_blk;
    logic [BLK_W-1:0] lat_blk;
    logic [WORDS-1:0] lat_mask;
    logic             lat_full, lat_empty;
    logic             clash, can_merge, need_flush, flush_ok;

    assign push     = in_valid && !fifo_full;
    assign in_ready = !fifo_full;

    cws_word_fifo #(.DEPTH(WORDS), .WIDTH(ENT_W)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din({in_last, in_addr, in_data}),
        .pop(pop), .dout(head),
        .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
    );

    assign {head_last, head_addr, head_data} = head;
    assign head_off = head_addr[OFF_W-1:0];
    assign head_blk = head_addr[ADDR_W-1:OFF_W];

    cws_merge_latch #(.WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)) latch_i (
        .clk(clk), .rst_n(rst_n),
        .load(pop), .load_blk(head_blk), .load_off(head_off),
        .load_data(head_data), .clear(lat_clear),
        .blk(lat_blk), .mask(lat_mask), .data(mem_data),
        .is_full(lat_full), .is_empty(lat_empty)
    );

    assign mem_blk = lat_blk;
    assign mem_wen = lat_mask;
    assign prio    = CNT_W'(WORDS) - fifo_count;

    // A queued word collides with the latch on a foreign block or a filled slot
    assign clash      = !lat_empty && ((head_blk != lat_blk) || lat_mask[head_off]);
    assign can_merge  = !fifo_empty && !clash;
    assign need_flush = !lat_empty && (lat_full || (!fifo_empty && clash));
    assign flush_ok   = (fifo_count >= CNT_W'(HALF)) || (eos_cnt != '0);

    // End-of-stream words waiting in the FIFO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eos_cnt <= '0;
        end else begin
            unique case ({push && in_last, pop && head_last})
                2'b10:   eos_cnt <= eos_cnt + 1'b1;
                2'b01:   eos_cnt <= eos_cnt - 1'b1;
                default: eos_cnt <= eos_cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_MERGE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_MERGE: begin
                if (can_merge) begin
                    if (head_last) nxt = ST_SEND;
                end else if (need_flush) begin
                    nxt = flush_ok ? ST_SEND : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (flush_ok) nxt = ST_SEND;
            end
            ST_SEND: begin
                if (mem_ack) nxt = ST_MERGE;
            end
            default: nxt = ST_MERGE;
        endcase
    end

    always_comb begin
        pop       = 1'b0;
        lat_clear = 1'b0;
        mem_req   = 1'b0;
        unique case (state)
            ST_MERGE: pop = can_merge;
            ST_HOLD:  pop = 1'b0;
            ST_SEND: begin
                mem_req   = 1'b1;
                lat_clear = mem_ack;
            end
            default: pop = 1'b0;
        endcase
    end
endmodule

// File: rtl/cws_checker.sv
module cws_checker #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_ready,
    input logic                              mem_req,
    input logic                              mem_ack,
    input logic [ADDR_W-$clog2(WORDS)-1:0]   mem_blk,
    input logic [WORDS-1:0]                  mem_wen,
    input logic [WORDS*DATA_W-1:0]           mem_data,
    input logic [$clog2(WORDS+1)-1:0]        prio
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);
    // R9
    payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_blk) && $stable(mem_wen) && $stable(mem_data)));
    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);
    // R4
    wen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_wen != '0));
    // R3
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (prio == '0));
    // R2
    prio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(prio) <= WORDS) &&
        ((prio == $past(prio)) || (int'(prio) == int'($past(prio)) + 1) ||
         (int'(prio) + 1 == int'($past(prio)))));
endmodule

bind coalescing_write_stream cws_checker #(
    .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_blk(mem_blk),
    .mem_wen(mem_wen), .mem_data(mem_data), .prio(prio)
);

// File: tb/coalescing_write_stream_tb_top.sv
module coalescing_write_stream_tb_top;
    localparam int WORDS = 8, DATA_W = 32, ADDR_W = 16, IMG = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic mem_req, mem_ack;
    logic [ADDR_W-4:0] mem_blk;
    logic [WORDS-1:0] mem_wen;
    logic [WORDS*DATA_W-1:0] mem_data;
    logic [3:0] prio;

    int checks = 0, failures = 0;
    logic ack_en = 1'b1;
    int   ack_delay = 2, wcnt;
    logic [31:0] img [IMG];
    logic [31:0] ref_img [IMG];
    logic [15:0]  log_blk  [64];
    logic [7:0]   log_wen  [64];
    logic [255:0] log_data [64];
    int log_n;

    always #5 clk = ~clk;

    coalescing_write_stream #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_blk(mem_blk),
        .mem_wen(mem_wen), .mem_data(mem_data), .prio(prio)
    );

    // Memory model: acknowledges ack_delay+1 edges after a request is seen
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
            log_n   <= 0;
            for (int i = 0; i < IMG; i++) img[i] <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req && ack_en) begin
            if (wcnt == ack_delay) begin
                mem_ack <= 1'b1;
                log_blk[log_n % 64]  <= 16'(mem_blk);
                log_wen[log_n % 64]  <= mem_wen;
                log_data[log_n % 64] <= mem_data;
                log_n <= log_n + 1;
                for (int i = 0; i < WORDS; i++) begin
                    if (mem_wen[i] && (int'(mem_blk) * 8 + i < IMG))
                        img[int'(mem_blk) * 8 + i] <= mem_data[i*32 +: 32];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int a, input logic [31:0] d, input logic l);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_addr = ADDR_W'(a); in_data = d; in_last = l;
        ref_img[a] = d;
        @(posedge clk);
        #1 in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int quiet = 0;
        int n = 0;
        while (quiet < 3 && n < 2000) begin
            @(negedge clk);
            n++;
            if (!mem_req && in_ready && prio == 4'd8) quiet++;
            else quiet = 0;
        end
        chk({tag, " drain completes"}, 64'(n < 2000), 64'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
        chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
        chk("R1 prio after reset", 64'(prio), 64'd8);
    endtask

    task automatic t_threshold();
        int base = log_n;
        push(6*8+0, 32'hA600_0000, 1'b0);
        chk("R2 prio after one accept", 64'(prio), 64'd7);
        @(posedge clk); #1;
        chk("R2 prio after move to latch", 64'(prio), 64'd8);
        push(7*8+0, 32'hA700_0000, 1'b0);
        repeat (10) @(negedge clk);
        chk("R7 held with one queued word", 64'(mem_req), 64'd0);
        push(7*8+1, 32'hA700_0001, 1'b0);
        push(7*8+2, 32'hA700_0002, 1'b0);
        repeat (6) @(negedge clk);
        chk("R7 held with three queued words", 64'(mem_req), 64'd0);
        push(7*8+3, 32'hA700_0003, 1'b0);
        @(negedge clk);
        chk("R7 request not yet raised", 64'(mem_req), 64'd0);
        @(negedge clk);
        chk("R7 request raised at half full", 64'(mem_req), 64'd1);
        chk("R6 first block sent alone", 64'(mem_blk), 64'd6);
        push(7*8+4, 32'hA700_0004, 1'b1);
        wait_idle("R8");
        chk("R8 request count", 64'(log_n - base), 64'd2);
        chk("R6 first wen", 64'(log_wen[base % 64]), 64'h01);
        chk("R8 second block", 64'(log_blk[(base+1) % 64]), 64'd7);
        chk("R8 second wen", 64'(log_wen[(base+1) % 64]), 64'h1F);
    endtask

    task automatic t_merge_sparse();
        int base = log_n;
        push(2*8+5, 32'hB205, 1'b0);
        push(2*8+1, 32'hB201, 1'b0);
        push(2*8+6, 32'hB206, 1'b1);
        wait_idle("R4");
        chk("R4 one request", 64'(log_n - base), 64'd1);
        chk("R4 block", 64'(log_blk[base % 64]), 64'd2);
        chk("R4 wen", 64'(log_wen[base % 64]), 64'h62);
        chk("R4 slot 5 data", 64'(log_data[base % 64][5*32 +: 32]), 64'hB205);
        chk("R4 slot 1 data", 64'(log_data[base % 64][1*32 +: 32]), 64'hB201);
    endtask

    task automatic t_merge_full();
        int base = log_n;
        for (int i = 7; i >= 0; i--) push(9*8+i, 32'hC900 + 32'(i), (i == 0));
        wait_idle("R4 full");
        chk("R4 reversed full block one request", 64'(log_n - base), 64'd1);
        chk("R4 reversed full block wen", 64'(log_wen[base % 64]), 64'hFF);
    endtask

    task automatic t_same_slot();
        int base = log_n;
        push(3*8+0, 32'hD0A, 1'b0);
        push(3*8+0, 32'hD0B, 1'b1);
        wait_idle("R5");
        chk("R5 two requests", 64'(log_n - base), 64'd2);
        chk("R5 first data", 64'(log_data[base % 64][31:0]), 64'hD0A);
        chk("R5 second data", 64'(log_data[(base+1) % 64][31:0]), 64'hD0B);
        chk("R5 memory holds newest", 64'(img[3*8]), 64'hD0B);
    endtask

    task automatic t_block_change();
        int base = log_n;
        push(4*8+2, 32'hE42, 1'b0);
        push(5*8+2, 32'hE52, 1'b1);
        wait_idle("R6");
        chk("R6 two requests", 64'(log_n - base), 64'd2);
        chk("R6 order first block", 64'(log_blk[base % 64]), 64'd4);
        chk("R6 order second block", 64'(log_blk[(base+1) % 64]), 64'd5);
    endtask

    task automatic t_full_fifo();
        int base = log_n;
        ack_en = 1'b0;
        for (int i = 0; i < 9; i++) push((16+i)*8, 32'hF000 + 32'(i), (i == 8));
        repeat (2) @(negedge clk);
        chk("R3 in_ready low when full", 64'(in_ready), 64'd0);
        chk("R3 prio zero when full", 64'(prio), 64'd0);
        in_valid = 1'b1; in_addr = ADDR_W'(255); in_data = 32'hDEAD; in_last = 1'b0;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        repeat (15) @(negedge clk);
        chk("R9 request held without ack", 64'(mem_req), 64'd1);
        chk("R9 held block stable", 64'(mem_blk), 64'd16);
        chk("R9 held wen stable", 64'(mem_wen), 64'h01);
        ack_en = 1'b1;
        wait_idle("R3");
        chk("R9 one request per block", 64'(log_n - base), 64'd9);
        chk("R9 latch cleared by ack", 64'(log_wen[(base+1) % 64]), 64'h01);
        chk("R3 refused write absent", 64'(img[255]), 64'h0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < IMG; i++) ref_img[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_threshold();
        t_merge_sparse();
        t_merge_full();
        t_same_slot();
        t_block_change();
        t_full_fifo();
        begin
            int bad = 0;
            for (int i = 0; i < IMG; i++) if (img[i] !== ref_img[i]) bad++;
            chk("R10 memory image mismatches", 64'(bad), 64'd0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule